// File: doc/BRIEF.md
# Dual-Channel Converter Input Front End

This block sits between a shared 8-bit parallel data bus and the core of a two-channel digital-to-analog converter. Each clock period carries two codes on the bus. The code for channel 2 is present before the falling clock edge, and the code for channel 1 is present before the next rising edge. The falling edge holds the channel-2 code in a preload latch. On the rising edge the channel-1 code and the preloaded channel-2 code are written into the two channel registers together. Both converter outputs therefore always change on the same edge. An active-low select gates every write.

The block also turns the two power-control pins into one of three power modes: run, idle and off. It drives the enables for the current array, the reference and the control amplifier from that mode. It forwards the choice between the internal and an external reference. A wake-up counter flags when the outputs can be trusted after the block returns to run mode. The channel codes are kept through idle and off, so the outputs return to their earlier values after wake-up.

Top module: `dac_pair_front`

## Requirements
- R1: The falling edge of `clk` latches `bus_d` (bit 7 is the MSB) into the preload while `cs_n` is low. The next rising edge with `cs_n` low writes `bus_d` to `ch1_code` and the preload to `ch2_code`.
- R2: `ch1_code` and `ch2_code` change only on rising edges, always on the same edge. They are visible from that edge onward.
- R3: While `cs_n` is high at both edges of a period, neither channel code changes.
- R4: `pwr_mode` is registered from `pd` and `dac_en` on each rising edge. `pd`=1 gives off (2'd0) whatever `dac_en` is. `pd`=0 with `dac_en`=0 gives idle (2'd1). `pd`=0 with `dac_en`=1 gives run (2'd2).
- R5: In run mode, `array_en`, `ref_en` and `amp_en` are all 1. In idle mode, `ref_en` and `amp_en` are 1 and `array_en` is 0. In off mode, all three are 0. These enables are registered on the same edge as `pwr_mode`.
- R6: `int_ref_en` is 1 only when `ref_sel_n` is 0 and the reference is enabled. It is registered on the same edge as `pwr_mode`.
- R7: `out_valid` rises exactly WAKE_CYC−1 clock cycles after `pwr_mode` first shows run. With the defaults of 40 MHz and 50 µs, WAKE_CYC is 2000. `out_valid` is 0 whenever `pwr_mode` is not run, and it falls on the same edge that `pwr_mode` leaves run.
- R8: The channel codes are not cleared by idle or off. After a return to run they still hold the last written values.
- R9: A rising edge with `rst` high clears both channel codes and the preload to 0, sets `pwr_mode` to off and clears `out_valid`. The falling edge also clears the preload while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| bus_d | input | 8 | Shared data bus, channel 2 before fall, channel 1 before rise |
| cs_n | input | 1 | Write select, active low |
| pd | input | 1 | Power-down request |
| dac_en | input | 1 | Run request when `pd` is low |
| ref_sel_n | input | 1 | 0 selects internal reference |
| ch1_code | output | 8 | Channel-1 code to the core |
| ch2_code | output | 8 | Channel-2 code to the core |
| array_en | output | 1 | Current-array enable |
| ref_en | output | 1 | Reference enable |
| amp_en | output | 1 | Control-amplifier enable |
| int_ref_en | output | 1 | Internal reference active |
| pwr_mode | output | 2 | 0 off, 1 idle, 2 run |
| out_valid | output | 1 | Outputs settled after wake-up |

## Verification
The bench writes pairs of codes whose halves differ, so a swapped channel, or a channel that takes the wrong edge's bus value, is caught. It uses the midscale step 0x7F/0x80 and the extremes 0x00/0xFF, which expose dropped or stuck bits. Deselected periods are placed between writes; they tell real holding apart from loading.

All three power modes are visited, including off with `dac_en` high, which shows that `pd` has priority. The wake-up delay is counted cycle by cycle after both a cold start and a return from off, which shows whether the counter restarts. Codes read after idle and off separate retention from clearing.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_IDLE = 2'd1,
    PM_RUN  = 2'd2
  } pwr_mode_t;

  function automatic pwr_mode_t decode_mode(input logic pd, input logic en);
    if (pd)      return PM_OFF;
    else if (en) return PM_RUN;
    else         return PM_IDLE;
  endfunction
endpackage

// File: rtl/dac_pwr_decode.sv
module dac_pwr_decode
  import dac_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pd,
  input  logic      dac_en,
  input  logic      ref_sel_n,
  output pwr_mode_t mode_q,
  output pwr_mode_t mode_nxt,
  output logic      array_en,
  output logic      ref_en,
  output logic      amp_en,
  output logic      int_ref_en
);
  logic bias_on;

  always_comb begin
    mode_nxt = decode_mode(pd, dac_en);
    bias_on  = (mode_nxt != PM_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_OFF;
      array_en   <= 1'b0;
      ref_en     <= 1'b0;
      amp_en     <= 1'b0;
      int_ref_en <= 1'b0;
    end else begin
      mode_q     <= mode_nxt;
      array_en   <= (mode_nxt == PM_RUN);
      ref_en     <= bias_on;
      amp_en     <= bias_on;
      int_ref_en <= bias_on & ~ref_sel_n;
    end
  end
endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
  parameter int WAKE_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic valid
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else if (cnt != FULL) begin
      cnt   <= cnt + 1'b1;
      valid <= valid | (cnt == LAST);
    end
  end
endmodule

// File: rtl/dac_dual_capture.sv
module dac_dual_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] bus_d,
  output logic [DATA_W-1:0] ch1_q,
  output logic [DATA_W-1:0] ch2_q
);
  logic [DATA_W-1:0] pre2;

  // Channel-2 code is taken while the clock is high, on its falling edge.
  always_ff @(negedge clk) begin
    if (rst)        pre2 <= '0;
    else if (!cs_n) pre2 <= bus_d;
  end

  // Both channel registers commit together on the rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ch1_q <= '0;
      ch2_q <= '0;
    end else if (!cs_n) begin
      ch1_q <= bus_d;
      ch2_q <= pre2;
    end
  end
endmodule

// File: rtl/dac_pair_front.sv
module dac_pair_front
  import dac_pair_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_MHZ = 40,
  parameter int WAKE_US = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_d,
  input  logic              cs_n,
  input  logic              pd,
  input  logic              dac_en,
  input  logic              ref_sel_n,
  output logic [DATA_W-1:0] ch1_code,
  output logic [DATA_W-1:0] ch2_code,
  output logic              array_en,
  output logic              ref_en,
  output logic              amp_en,
  output logic              int_ref_en,
  output logic [1:0]        pwr_mode,
  output logic              out_valid
);
  localparam int WAKE_CYC = CLK_MHZ * WAKE_US;

  pwr_mode_t mode_q, mode_nxt;

  dac_dual_capture #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .bus_d (bus_d),
    .ch1_q (ch1_code),
    .ch2_q (ch2_code)
  );

  dac_pwr_decode u_pwr (
    .clk        (clk),
    .rst        (rst),
    .pd         (pd),
    .dac_en     (dac_en),
    .ref_sel_n  (ref_sel_n),
    .mode_q     (mode_q),
    .mode_nxt   (mode_nxt),
    .array_en   (array_en),
    .ref_en     (ref_en),
    .amp_en     (amp_en),
    .int_ref_en (int_ref_en)
  );

  dac_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst   (rst),
    .run   (mode_nxt == PM_RUN),
    .valid (out_valid)
  );

  assign pwr_mode = mode_q;
endmodule

// File: rtl/dac_pair_front_chk.sv
module dac_pair_front_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic [DATA_W-1:0] ch1_code,
  input logic [DATA_W-1:0] ch2_code,
  input logic              array_en,
  input logic              ref_en,
  input logic              amp_en,
  input logic              int_ref_en,
  input logic [1:0]        pwr_mode,
  input logic              out_valid
);
  // R3: deselected rising edge leaves channel 1 unchanged
  p_ch1_hold_r3: assert property (@(posedge clk) (!rst && cs_n) |=> $stable(ch1_code));
  // R3: deselected rising edge leaves channel 2 unchanged
  p_ch2_hold_r3: assert property (@(posedge clk) (!rst && cs_n) |=> $stable(ch2_code));
  // R5: array only powered when bias is powered
  p_array_bias_r5: assert property (@(posedge clk) disable iff (rst)
    array_en |-> (ref_en && amp_en));
  // R5: off mode removes reference and amplifier
  p_off_dark_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode == 2'd0) |-> (!ref_en && !amp_en && !array_en));
  // R6: internal reference never on without reference enable
  p_intref_r6: assert property (@(posedge clk) disable iff (rst)
    int_ref_en |-> ref_en);
  // R7: valid only in run mode
  p_valid_run_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pwr_mode == 2'd2));
  // R7: valid rises only after a run cycle
  p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(pwr_mode) == 2'd2));
  // R9: reset clears codes and valid
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (ch1_code == '0 && ch2_code == '0 && !out_valid && pwr_mode == 2'd0));
endmodule

bind dac_pair_front dac_pair_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .ch1_code   (ch1_code),
  .ch2_code   (ch2_code),
  .array_en   (array_en),
  .ref_en     (ref_en),
  .amp_en     (amp_en),
  .int_ref_en (int_ref_en),
  .pwr_mode   (pwr_mode),
  .out_valid  (out_valid)
);

// File: tb/dac_pair_front_bench.sv
module dac_pair_front_bench;
  localparam int WAKE = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_d = 8'h00;
  logic       cs_n = 1'b1;
  logic       pd = 1'b1;
  logic       dac_en = 1'b0;
  logic       ref_sel_n = 1'b0;
  logic [7:0] ch1_code, ch2_code;
  logic       array_en, ref_en, amp_en, int_ref_en, out_valid;
  logic [1:0] pwr_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_q [$];
  logic [7:0]  m1 = 8'h00, m2 = 8'h00;

  always #5 clk = ~clk;

  dac_pair_front u_dac_pair_front (
    .clk(clk), .rst(rst), .bus_d(bus_d), .cs_n(cs_n), .pd(pd),
    .dac_en(dac_en), .ref_sel_n(ref_sel_n), .ch1_code(ch1_code),
    .ch2_code(ch2_code), .array_en(array_en), .ref_en(ref_en),
    .amp_en(amp_en), .int_ref_en(int_ref_en), .pwr_mode(pwr_mode),
    .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: one clock period carrying c2 then c1; pushes expected codes.
  task automatic put_pair(input logic [7:0] c1, input logic [7:0] c2, input logic sel);
    @(posedge clk); #1;
    cs_n  = ~sel;
    bus_d = c2;
    @(negedge clk); #1;
    bus_d = c1;
    if (sel) begin m1 = c1; m2 = c2; end
    exp_q.push_back({m1, m2});
  endtask

  // Monitor: compare after each rising edge against scoreboard.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check("R1/R2/R3 ch1", {24'h0, ch1_code}, {24'h0, e[15:8]});
        check("R1/R2/R3 ch2", {24'h0, ch2_code}, {24'h0, e[7:0]});
      end
    end
  end

  task automatic set_mode(input logic p, input logic e);
    @(posedge clk); #1;
    pd = p; dac_en = e;
    @(posedge clk); #2;
  endtask

  task automatic wait_wake(input string req);
    int cyc;
    cyc = 0;
    while (pwr_mode != 2'd2 && cyc < 10) begin @(posedge clk); #2; cyc++; end
    check({req, " run seen"}, {30'h0, pwr_mode}, 32'd2);
    check({req, " valid low at run"}, {31'h0, out_valid}, 32'd0);
    cyc = 0;
    while (!out_valid && cyc < WAKE + 5) begin @(posedge clk); #2; cyc++; end
    check({req, " wake cycles"}, cyc, WAKE - 1);
  endtask

  initial begin
    cs_n = 1'b0; bus_d = 8'hA5;
    repeat (3) @(posedge clk);
    #2;
    check("R9 ch1 reset", {24'h0, ch1_code}, 32'h0);
    check("R9 ch2 reset", {24'h0, ch2_code}, 32'h0);
    check("R9 valid reset", {31'h0, out_valid}, 32'h0);
    check("R9 mode reset", {30'h0, pwr_mode}, 32'h0);
    #1 rst = 1'b0; cs_n = 1'b1;
    @(posedge clk); #2;
    check("R4 off pd=1", {30'h0, pwr_mode}, 32'd0);
    check("R5 off enables", {29'h0, array_en, ref_en, amp_en}, 32'd0);
    check("R6 off intref", {31'h0, int_ref_en}, 32'd0);

    // Cold start to run
    @(posedge clk); #1; pd = 1'b0; dac_en = 1'b1;
    wait_wake("R7 cold");
    check("R5 run enables", {29'h0, array_en, ref_en, amp_en}, 32'd7);
    check("R6 run intref", {31'h0, int_ref_en}, 32'd1);

    // Data patterns through scoreboard
    put_pair(8'h12, 8'hE7, 1'b1);
    put_pair(8'h7F, 8'h80, 1'b1);
    put_pair(8'h80, 8'h7F, 1'b1);
    put_pair(8'hFF, 8'h00, 1'b1);
    put_pair(8'h3C, 8'hC3, 1'b0);
    put_pair(8'h55, 8'h99, 1'b0);
    put_pair(8'h00, 8'hFF, 1'b1);
    put_pair(8'h6A, 8'h01, 1'b1);
    put_pair(8'hDE, 8'hAD, 1'b0);
    @(posedge clk); #1; cs_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;

    // Idle
    set_mode(1'b0, 1'b0);
    check("R4 idle", {30'h0, pwr_mode}, 32'd1);
    check("R5 idle enables", {29'h0, array_en, ref_en, amp_en}, 32'd3);
    check("R7 valid off in idle", {31'h0, out_valid}, 32'd0);
    check("R8 ch1 held idle", {24'h0, ch1_code}, 32'h6A);
    check("R8 ch2 held idle", {24'h0, ch2_code}, 32'h01);
    @(posedge clk); #1; ref_sel_n = 1'b1;
    @(posedge clk); #2;
    check("R6 external ref", {31'h0, int_ref_en}, 32'd0);
    @(posedge clk); #1; ref_sel_n = 1'b0;
    @(posedge clk); #2;
    check("R6 internal ref idle", {31'h0, int_ref_en}, 32'd1);

    // Off with dac_en high: pd has priority
    set_mode(1'b1, 1'b1);
    check("R4 off priority", {30'h0, pwr_mode}, 32'd0);
    check("R5 off enables 2", {29'h0, array_en, ref_en, amp_en}, 32'd0);
    check("R8 ch1 held off", {24'h0, ch1_code}, 32'h6A);

    // Return to run, timer restarts
    @(posedge clk); #1; pd = 1'b0; dac_en = 1'b1;
    wait_wake("R7 rewake");
    check("R8 ch1 after wake", {24'h0, ch1_code}, 32'h6A);
    check("R8 ch2 after wake", {24'h0, ch2_code}, 32'h01);

    // Leaving run drops valid together with mode
    set_mode(1'b0, 1'b0);
    check("R7 valid drops", {31'h0, out_valid}, 32'd0);
    check("R4 idle again", {30'h0, pwr_mode}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule